// File: doc/BRIEF.md
# NAND Flash PIO Command Sequencer

This block drives a raw 8-bit NAND flash bus through one whole operation each time software starts it. Software first loads a first and a second command byte, two address words, a 32-bit data word and a strobe-timing word through a small register write port. It then writes a command word whose top bit starts the operation. The command word chooses which phases run: a command-latch byte, a run of address-latch bytes, a programmed-I/O data transfer of one to four bytes in either direction, and a second command byte. It also chooses whether the data transfer comes before or after the second command.

The start bit reads back as `go_o` for as long as the operation runs and drops when it finishes. After every second command the sequencer holds the bus quiet until the ready/busy line reports ready. Only then does it move on to a data phase or finish. Bytes read from the flash are packed into the data word, first byte lowest, when the operation completes. Write-strobe and read-strobe low and high widths come from two counts in the timing word.

Top module: `nand_pio_seq`

## Requirements
- R1: After a synchronous active-low reset, `go_o` is 0, `data_o` is 0, `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, and `nand_cle`, `nand_ale` and `nand_dq_oe` are 0.
- R2: When command-word bit 25 (data-after-address) is 0, the enabled phases appear on the bus in this order: first command (register select 0), address bytes, second command (register select 1), then data.
- R3: When command-word bit 25 is 1, the enabled phases appear in this order: first command, address bytes, data, second command.
- R4: The first command runs only if bit 30 is set, and the second command only if bit 26 is set. The address phase runs only if bit 29 is set. It puts out N bytes, where N is bits 18:16 with values above 5 taken as 5. Address bytes 0 to 3 are bits 7:0 to 31:24 of address word 1 (select 2), and byte 4 is bits 7:0 of address word 2 (select 3). CLE is high only during command bytes and ALE only during address bytes.
- R5: The data phase runs only if bit 28 is set. It moves bits 21:20 plus one bytes. With bit 27 set it writes to the flash, and byte k is bits 8k+7:8k of the data word (select 4).
- R6: With bit 28 set and bit 27 clear, the bytes read are packed little-endian into the data word when the operation completes. Bytes beyond the transfer size read as 0.
- R7: After a second command, no strobe falls and `go_o` does not clear while `nand_rb` is low.
- R8: Every `nand_we_n` and `nand_re_n` low pulse lasts timing bits 3:0 plus one clocks (timing word, select 5). CLE, ALE and the driven byte do not change when a write strobe falls or rises. The two strobes are never low together.
- R9: Writing select 6 with bit 31 set raises `go_o` on the next clock, and `go_o` falls when the last phase ends. `nand_ce_n` is low during strobes exactly when bit 24 was set, and it is high whenever `go_o` is 0.
- R10: Register writes made while `go_o` is 1 are ignored. This covers the command word, so such a write does not restart or change the running operation, and it covers the data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 cmd1, 1 cmd2, 2 addr word 1, 3 addr word 2, 4 data, 5 timing, 6 command word |
| reg_wdata | input | 32 | Register write data |
| go_o | output | 1 | Operation running |
| data_o | output | 32 | Current data word |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Byte driven onto the flash bus |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_o` |
| nand_dq_i | input | 8 | Byte read from the flash bus |
| nand_rb | input | 1 | Ready (1) / busy (0) from the flash |

## Verification
The bench sweeps every combination of phase enables, address counts including the clamped value, both phase orders and every transfer size in both directions, under several strobe widths. It compares the decoded bus trace with an arithmetic model. A sequencer that mixed up the two orderings would put the second command on the wrong side of the data. One that packed read bytes in the wrong order, or left stale upper bytes, would show a wrong data word. The flash model holds ready/busy low for several clocks after each second command, so a design that skipped the wait would strobe during busy or drop `go_o` early. A start command written in the middle of a program checks that a busy sequencer neither restarts nor loses its data word.

// File: rtl/nand_seq_pkg.sv
// Shared types and field positions for the NAND PIO sequencer.
// Assumes an 8-bit flash bus, at most five address bytes and a 32-bit data word.
package nand_seq_pkg;

    localparam int MAX_ADDR   = 5;
    localparam int DATA_BYTES = 4;
    localparam int DIDX_W     = $clog2(DATA_BYTES);

    // register selects
    localparam logic [2:0] SEL_CMD1  = 3'd0;
    localparam logic [2:0] SEL_CMD2  = 3'd1;
    localparam logic [2:0] SEL_ADDR1 = 3'd2;
    localparam logic [2:0] SEL_ADDR2 = 3'd3;
    localparam logic [2:0] SEL_DATA  = 3'd4;
    localparam logic [2:0] SEL_TIME  = 3'd5;
    localparam logic [2:0] SEL_CMDW  = 3'd6;

    // command word bit positions
    localparam int CW_GO    = 31;
    localparam int CW_CLE   = 30;
    localparam int CW_ALE   = 29;
    localparam int CW_PIO   = 28;
    localparam int CW_TX    = 27;
    localparam int CW_SEC   = 26;
    localparam int CW_DAFT  = 25;
    localparam int CW_CE    = 24;
    localparam int CW_SIZE  = 20;
    localparam int CW_ACNT  = 16;

    typedef enum logic [2:0] {
        S_IDLE, S_CMD1, S_ADDR, S_DOUT, S_CMD2, S_WAITRB, S_DIN
    } seq_state_t;

    typedef struct packed {
        logic       cle_en;
        logic       ale_en;
        logic       pio;
        logic       tx;
        logic       sec;
        logic       dafter;
        logic       ce;
        logic [1:0] size;
        logic [2:0] acnt;
    } cmd_word_t;

endpackage

// File: rtl/nand_strobe_timer.sv
// Times one bus byte: an idle launch cycle, a low phase of low_cnt+1 clocks
// and a high phase of high_cnt+1 clocks. Counts must stay stable while busy.
module nand_strobe_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic [CNT_W-1:0] high_cnt,
    output logic             strobe_low,
    output logic             sample,
    output logic             done,
    output logic             busy
);
    typedef enum logic [1:0] {T_IDLE, T_LOW, T_HIGH} tphase_t;

    tphase_t          ph_q;
    logic [CNT_W-1:0] cnt_q;

    // phase and countdown for the current byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= T_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (ph_q)
                T_IDLE: if (start) begin
                    ph_q  <= T_LOW;
                    cnt_q <= low_cnt;
                end
                T_LOW: if (cnt_q == '0) begin
                    ph_q  <= T_HIGH;
                    cnt_q <= high_cnt;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                T_HIGH: if (cnt_q == '0) ph_q <= T_IDLE;
                        else cnt_q <= cnt_q - 1'b1;
                default: ph_q <= T_IDLE;
            endcase
        end
    end

    assign strobe_low = (ph_q == T_LOW);
    assign sample     = (ph_q == T_LOW)  && (cnt_q == '0);
    assign done       = (ph_q == T_HIGH) && (cnt_q == '0);
    assign busy       = (ph_q != T_IDLE);

endmodule

// File: rtl/nand_byte_path.sv
// Picks the outgoing address or data byte by index and gathers read bytes
// into little-endian lanes. The lanes clear while the sequencer is idle.
module nand_byte_path
    import nand_seq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    cap,
    input  logic [2:0]              idx,
    input  logic [7:0]              dq_i,
    input  logic [31:0]             addr1,
    input  logic [7:0]              addr2,
    input  logic [8*DATA_BYTES-1:0] data_word,
    output logic [7:0]              addr_byte,
    output logic [7:0]              tx_byte,
    output logic [8*DATA_BYTES-1:0] rx_word
);
    logic [7:0] abyte [MAX_ADDR];
    logic [7:0] dbyte [DATA_BYTES];

    for (genvar g = 0; g < 4; g++) begin : g_abyte
        assign abyte[g] = addr1[8*g +: 8];
    end
    assign abyte[4] = addr2;

    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
        logic [7:0] lane_q;
        assign dbyte[g] = data_word[8*g +: 8];
        // capture the read byte that belongs to this lane
        always_ff @(posedge clk) begin
            if (!rst_n || clr)                  lane_q <= '0;
            else if (cap && idx == 3'(g))       lane_q <= dq_i;
        end
        assign rx_word[8*g +: 8] = lane_q;
    end

    assign addr_byte = (idx < 3'(MAX_ADDR)) ? abyte[idx] : '0;
    assign tx_byte   = dbyte[idx[DIDX_W-1:0]];

endmodule

// File: rtl/nand_pio_seq.sv
// NAND flash PIO sequencer: holds the program registers and steps through the
// command, address, data and second-command phases chosen by the command word.
// Assumes one flash chip and that its ready/busy line is already synchronous.
module nand_pio_seq
    import nand_seq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic        go_o,
    output logic [31:0] data_o,
    output logic        nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_dq_o,
    output logic        nand_dq_oe,
    input  logic [7:0]  nand_dq_i,
    input  logic        nand_rb
);
    logic [7:0]       cmd1_q, cmd2_q, addr2_q;
    logic [31:0]      addr1_q, data_q;
    logic [CNT_W-1:0] tlow_q, thigh_q;
    cmd_word_t        cw_q;
    logic             go_q;
    seq_state_t       st_q, st_nxt;
    seq_state_t       data_st, after_addr, after_cmd1, first_st, after_data, after_rb;
    logic [2:0]       idx_q;
    logic             last_addr, last_data, finish, byte_state, in_rb_wait, rb_release;
    logic             tmr_low, tmr_sample, tmr_done, tmr_busy;
    logic [7:0]       addr_byte, tx_byte;
    logic [31:0]      rx_word;

    assign in_rb_wait = (st_q == S_WAITRB);
    assign rb_release = in_rb_wait && nand_rb;
    assign finish     = go_q && (st_nxt == S_IDLE);
    assign byte_state = (st_q == S_CMD1) || (st_q == S_ADDR) || (st_q == S_DOUT)
                     || (st_q == S_CMD2) || (st_q == S_DIN);

    // register file: writes only while idle, start bit, read-data update at finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd1_q <= '0; cmd2_q <= '0; addr1_q <= '0; addr2_q <= '0;
            data_q <= '0; tlow_q <= '0; thigh_q <= '0; cw_q <= '0; go_q <= 1'b0;
        end else if (finish) begin
            go_q <= 1'b0;
            if (cw_q.pio && !cw_q.tx) data_q <= rx_word;
        end else if (reg_we && !go_q) begin
            unique case (reg_sel)
                SEL_CMD1:  cmd1_q  <= reg_wdata[7:0];
                SEL_CMD2:  cmd2_q  <= reg_wdata[7:0];
                SEL_ADDR1: addr1_q <= reg_wdata;
                SEL_ADDR2: addr2_q <= reg_wdata[7:0];
                SEL_DATA:  data_q  <= reg_wdata;
                SEL_TIME: begin
                    tlow_q  <= reg_wdata[CNT_W-1:0];
                    thigh_q <= reg_wdata[2*CNT_W-1:CNT_W];
                end
                SEL_CMDW: begin
                    go_q        <= reg_wdata[CW_GO];
                    cw_q.cle_en <= reg_wdata[CW_CLE];
                    cw_q.ale_en <= reg_wdata[CW_ALE];
                    cw_q.pio    <= reg_wdata[CW_PIO];
                    cw_q.tx     <= reg_wdata[CW_TX];
                    cw_q.sec    <= reg_wdata[CW_SEC];
                    cw_q.dafter <= reg_wdata[CW_DAFT];
                    cw_q.ce     <= reg_wdata[CW_CE];
                    cw_q.size   <= reg_wdata[CW_SIZE +: 2];
                    cw_q.acnt   <= (reg_wdata[CW_ACNT +: 3] > 3'(MAX_ADDR)) ?
                                   3'(MAX_ADDR) : reg_wdata[CW_ACNT +: 3];
                end
                default: ;
            endcase
        end
    end

    // phase ordering: pick the successor of each phase from the command word
    always_comb begin
        data_st    = cw_q.tx ? S_DOUT : S_DIN;
        after_addr = (cw_q.pio && cw_q.dafter) ? data_st :
                     cw_q.sec ? S_CMD2 : cw_q.pio ? data_st : S_IDLE;
        after_cmd1 = (cw_q.ale_en && cw_q.acnt != 3'd0) ? S_ADDR : after_addr;
        first_st   = cw_q.cle_en ? S_CMD1 : after_cmd1;
        after_data = (cw_q.dafter && cw_q.sec) ? S_CMD2 : S_IDLE;
        after_rb   = (cw_q.pio && !cw_q.dafter) ? data_st : S_IDLE;
        last_addr  = (idx_q == cw_q.acnt - 3'd1);
        last_data  = (idx_q == {1'b0, cw_q.size});
        st_nxt     = st_q;
        unique case (st_q)
            S_IDLE:   if (go_q) st_nxt = first_st;
            S_CMD1:   if (tmr_done) st_nxt = after_cmd1;
            S_ADDR:   if (tmr_done && last_addr) st_nxt = after_addr;
            S_DOUT,
            S_DIN:    if (tmr_done && last_data) st_nxt = after_data;
            S_CMD2:   if (tmr_done) st_nxt = S_WAITRB;
            S_WAITRB: if (rb_release) st_nxt = after_rb;
            default:  st_nxt = S_IDLE;
        endcase
    end

    // state and byte index within the current phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            idx_q <= '0;
        end else begin
            st_q <= st_nxt;
            if (st_nxt != st_q) idx_q <= '0;
            else if (tmr_done)  idx_q <= idx_q + 3'd1;
        end
    end

    nand_strobe_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(byte_state && !tmr_busy),
        .low_cnt(tlow_q), .high_cnt(thigh_q), .strobe_low(tmr_low),
        .sample(tmr_sample), .done(tmr_done), .busy(tmr_busy)
    );

    nand_byte_path u_bytes (
        .clk(clk), .rst_n(rst_n), .clr(st_q == S_IDLE),
        .cap(tmr_sample && st_q == S_DIN), .idx(idx_q), .dq_i(nand_dq_i),
        .addr1(addr1_q), .addr2(addr2_q), .data_word(data_q),
        .addr_byte(addr_byte), .tx_byte(tx_byte), .rx_word(rx_word)
    );

    // bus pins derived from phase and strobe timer
    always_comb begin
        nand_cle   = (st_q == S_CMD1) || (st_q == S_CMD2);
        nand_ale   = (st_q == S_ADDR);
        nand_dq_oe = nand_cle || nand_ale || (st_q == S_DOUT);
        unique case (st_q)
            S_CMD1:  nand_dq_o = cmd1_q;
            S_CMD2:  nand_dq_o = cmd2_q;
            S_ADDR:  nand_dq_o = addr_byte;
            S_DOUT:  nand_dq_o = tx_byte;
            default: nand_dq_o = '0;
        endcase
        nand_we_n = !(tmr_low && nand_dq_oe);
        nand_re_n = !(tmr_low && st_q == S_DIN);
        nand_ce_n = !(go_q && cw_q.ce);
    end

    assign go_o   = go_q;
    assign data_o = data_q;

endmodule

// File: rtl/nand_pio_seq_chk.sv
// Protocol checker for nand_pio_seq, attached by bind. It reads the top-level
// pins plus the ready/busy-wait indication.
module nand_pio_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic        go_o,
    input logic [31:0] data_o,
    input logic        nand_ce_n,
    input logic        nand_cle,
    input logic        nand_ale,
    input logic        nand_we_n,
    input logic        nand_re_n,
    input logic [7:0]  nand_dq_o,
    input logic        nand_rb,
    input logic        in_rb_wait
);
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    p_latch_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    p_we_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_we_n) |-> $stable(nand_dq_o) && $stable(nand_cle) && $stable(nand_ale));

    p_we_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> $stable(nand_dq_o) && $stable(nand_cle) && $stable(nand_ale));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !go_o |-> nand_we_n && nand_re_n && !nand_cle && !nand_ale && nand_ce_n);

    p_rb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_rb_wait && !nand_rb |=> in_rb_wait && go_o);

    p_rb_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_rb_wait |-> nand_we_n && nand_re_n);

    p_busy_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        go_o && reg_we |=> !go_o || $stable(data_o));

endmodule

bind nand_pio_seq nand_pio_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .go_o(go_o), .data_o(data_o),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
    .nand_rb(nand_rb), .in_rb_wait(in_rb_wait)
);

// File: tb/nand_pio_seq_bench.sv
// Bench: sweeps phase enables, orderings, address counts and transfer sizes
// against a simple flash model, and checks traces and data words arithmetically.
module nand_pio_seq_bench;
    localparam int BUSY_CYC = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        go_o, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [31:0] data_o;
    logic [7:0]  nand_dq_o, nand_dq_i;
    logic        rb = 1'b1;

    int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0, wd_fail = 0;
    int log_n = 0, rd_count = 0, busy = 0, lowcnt = 0, exp_tlow = 0;
    logic exp_ce_n = 1'b1, prev_we = 1'b1, prev_re = 1'b1;
    int log_kind [64];
    logic [7:0] log_val [64];

    always #10 clk = ~clk;

    function automatic logic [7:0] rdval(int k);
        return 8'(8'h5A + k * 29);
    endfunction

    assign nand_dq_i = rdval(rd_count);

    nand_pio_seq u_nand_pio_seq (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .go_o(go_o), .data_o(data_o),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
        .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb(rb)
    );

    // flash model and pin monitor: logs bytes, times strobes, drives ready/busy
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_we = 1'b1; prev_re = 1'b1; rb = 1'b1; busy = 0; lowcnt = 0;
        end else begin
            if (busy > 0) begin
                busy = busy - 1;
                if (busy == 0) rb = 1'b1;
            end
            if (!nand_we_n || !nand_re_n) begin
                lowcnt = lowcnt + 1;
                mon_checks = mon_checks + 2;
                if (!rb) begin
                    mon_fails = mon_fails + 1;
                    $display("FAIL R7: strobe while busy, rb=%0d expected 1", rb);
                end
                if (nand_ce_n != exp_ce_n) begin
                    mon_fails = mon_fails + 1;
                    $display("FAIL R9: ce_n=%0d expected %0d", nand_ce_n, exp_ce_n);
                end
            end
            if ((!prev_we && nand_we_n) || (!prev_re && nand_re_n)) begin
                mon_checks = mon_checks + 1;
                if (lowcnt != exp_tlow + 1) begin
                    mon_fails = mon_fails + 1;
                    $display("FAIL R8: strobe low %0d clocks expected %0d", lowcnt, exp_tlow + 1);
                end
                lowcnt = 0;
                if (!prev_we) begin
                    log_kind[log_n % 64] = nand_cle ? 1 : (nand_ale ? 2 : 3);
                    log_val[log_n % 64]  = nand_dq_o;
                    if (nand_cle && (nand_dq_o == 8'h30 || nand_dq_o == 8'h10)) begin
                        rb = 1'b0; busy = BUSY_CYC;
                    end
                end else begin
                    log_kind[log_n % 64] = 4;
                    log_val[log_n % 64]  = rdval(rd_count);
                    rd_count = rd_count + 1;
                end
                log_n = log_n + 1;
            end
            prev_we = nand_we_n;
            prev_re = nand_re_n;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks + mon_checks, fails + mon_fails + wd_fail);
    endtask

    initial begin
        repeat (200000) @(negedge clk);
        wd_fail = 1;
        $display("FAIL watchdog: run hung, cycles=200000 expected fewer");
        summary();
        $finish;
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] sel, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // program and run one operation, then compare trace and data word
    task automatic run_op(bit cle, int acode, bit pio, bit tx, bit sec, bit dafter,
                          bit ce, int size, int tl, int th, bit intrude, int opn);
        logic [7:0]  c1, c2, a2;
        logic [31:0] a1, dat, w, exp_data;
        int ek [16];
        logic [7:0] ev [16];
        int ne = 0, nacnt, base_log, base_rd, guard = 0;
        bit ale = (acode != 0);
        c1  = dafter ? 8'h80 : 8'h00;
        c2  = dafter ? 8'h10 : 8'h30;
        a1  = 32'h0F1E2D3C + 32'(opn) * 32'h01030507;
        a2  = 8'(8'h40 + opn);
        dat = 32'hC0DE0000 ^ (32'(opn) << 4) ^ 32'(opn * 7);
        nacnt = ale ? ((acode > 5) ? 5 : acode) : 0;
        wr(3'd0, {24'h0, c1}); wr(3'd1, {24'h0, c2}); wr(3'd2, a1);
        wr(3'd3, {24'h0, a2}); wr(3'd4, dat); wr(3'd5, 32'((th << 4) | tl));
        base_log = log_n; base_rd = rd_count; exp_ce_n = !ce; exp_tlow = tl;
        // expected trace: kind 1 command, 2 address, 3 data out, 4 data in
        if (cle) begin ek[ne] = 1; ev[ne] = c1; ne++; end
        for (int i = 0; i < nacnt; i++) begin
            ek[ne] = 2; ev[ne] = (i < 4) ? a1[8*i +: 8] : a2; ne++;
        end
        exp_data = tx || !pio ? dat : 32'h0;
        for (int pass = 0; pass < 2; pass++) begin
            if ((pass == 0) == dafter && pio)
                for (int j = 0; j <= size; j++) begin
                    ek[ne] = tx ? 3 : 4;
                    ev[ne] = tx ? dat[8*j +: 8] : rdval(base_rd + j);
                    if (!tx) exp_data[8*j +: 8] = rdval(base_rd + j);
                    ne++;
                end
            if (pass == 0 && sec) begin ek[ne] = 1; ev[ne] = c2; ne++; end
        end
        w = '0;
        w[31] = 1'b1; w[30] = cle; w[29] = ale; w[28] = pio; w[27] = tx;
        w[26] = sec; w[25] = dafter; w[24] = ce; w[21:20] = 2'(size); w[18:16] = 3'(acode);
        wr(3'd6, w);
        chk(go_o == 1'b1, "R9 go set after start", int'(go_o), 1);
        if (intrude) begin
            wr(3'd4, 32'hDEADBEEF);
            wr(3'd6, 32'hC000_0000);
        end
        while (go_o && guard < 5000) begin @(negedge clk); guard++; end
        chk(guard < 5000, "R9 go cleared", guard, 0);
        if (sec) chk(rb == 1'b1, "R7 go cleared only when ready", int'(rb), 1);
        if (intrude) begin
            repeat (4) @(negedge clk);
            chk(go_o == 1'b0, "R10 no restart from locked write", int'(go_o), 0);
        end
        chk(log_n - base_log == ne, dafter ? "R3 phase count" : "R4 phase count",
            log_n - base_log, ne);
        for (int i = 0; i < ne && i < log_n - base_log; i++) begin
            chk(log_kind[(base_log + i) % 64] == ek[i],
                dafter ? "R3 phase kind" : "R2 phase kind", log_kind[(base_log + i) % 64], ek[i]);
            chk(log_val[(base_log + i) % 64] == ev[i],
                ek[i] == 2 ? "R4 address byte" : (ek[i] == 3 ? "R5 write byte" : "R2 bus byte"),
                int'(log_val[(base_log + i) % 64]), int'(ev[i]));
        end
        chk(data_o == exp_data, intrude ? "R10 data word kept" : (pio && !tx ? "R6 read word" : "R5 data word"),
            int'(data_o), int'(exp_data));
    endtask

    initial begin
        int opn = 0;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(go_o == 1'b0 && data_o == 32'h0, "R1 go/data reset", int'(data_o), 0);
        chk(nand_ce_n && nand_we_n && nand_re_n, "R1 active-low pins high",
            int'({nand_ce_n, nand_we_n, nand_re_n}), 7);
        chk(!nand_cle && !nand_ale && !nand_dq_oe, "R1 latch enables low",
            int'({nand_cle, nand_ale, nand_dq_oe}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // sweep phases, orders, address counts, direction and size
        for (int cle = 0; cle < 2; cle++)
            for (int ai = 0; ai < 5; ai++)
                for (int sec = 0; sec < 2; sec++)
                    for (int da = 0; da < 2; da++)
                        for (int dv = 0; dv < 9; dv++) begin
                            int acode = (ai == 0) ? 0 : (ai == 1) ? 2 : (ai == 2) ? 3 : (ai == 3) ? 5 : 7;
                            bit pio = (dv != 0);
                            bit tx  = (dv > 4);
                            int sz  = pio ? (dv - 1) % 4 : 0;
                            run_op(cle[0], acode, pio, tx, sec[0], da[0], (opn % 7) != 3,
                                   sz, opn % 3, (opn / 3) % 3, 1'b0, opn);
                            opn++;
                        end
        // R10: page program interrupted by locked register writes
        run_op(1'b1, 5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3, 3, 2, 1'b1, opn);
        // R6: single status byte read, upper bytes zero
        run_op(1'b1, 0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 0, 1, 1, 1'b0, opn + 1);
        summary();
        $finish;
    end

endmodule